// File: doc/BRIEF.md
# Streaming Pixel Color Transform Stage

This block sits in a pixel stream and rewrites each pixel's three color components while leaving its alpha untouched. One datapath serves three modes chosen by a register: a neutral bypass, a programmable 3x3 matrix product with a per-output offset (used, for example, to turn luma/chroma pixels into red/green/blue), and alpha pre-multiplication of the color components. All arithmetic is fixed point, with round-to-nearest and clamping to the 8-bit component range.

Pixels enter and leave through valid/ready handshakes. The pipeline is three registers deep and stalls as a unit when the consumer withholds ready. The mode, the nine coefficients and the three offsets are loaded through a plain write port into a staging copy. That copy becomes live only once every pixel already in the pipeline has left, so no pixel is ever computed with a mix of old and new settings.

Top module: `color_xform`

## Requirements
- R1: After reset, outValid is 0, inReady is 1, the mode is neutral, the matrix is the identity and the offsets are zero, so the first pixels come out unchanged.
- R2: In neutral mode (mode code 0), each output component equals the matching input component.
- R3: In matrix mode (mode code 1), output component r is floor((sum over k of K[r][k]*in[k] + 1024*O[r] + 512) / 1024). Coefficients K are 12-bit two's complement with 10 fraction bits, and offsets O are 10-bit two's complement integers.
- R4: A matrix result below 0 is output as 0, and a result above 255 is output as 255.
- R5: In pre-multiply mode (mode code 2), with p = c*alpha, each color output is ((p+128) + ((p+128)>>8)) >> 8.
- R6: The alpha output equals the alpha that entered with the same pixel, in every mode.
- R7: With outReady held high, a pixel accepted in cycle t is presented with outValid high in cycle t+3. Pixels leave in the order they arrived.
- R8: While outValid is high and outReady is low, inReady is low, and in the next cycle outValid stays high with the output pixel unchanged.
- R9: A write sets one register: address 0..8 sets K[r][k] at address 3r+k from data bits 11:0, address 9..11 sets O[address-9] from bits 9:0, and address 12 sets the mode from bits 1:0, where code 3 behaves as neutral. Writes to addresses 13..15 have no effect.
- R10: A write in cycle t applies to every pixel accepted after cycle t and to no pixel accepted in or before it. inReady is low in cycle t+1 and stays low until the pipeline is empty and the new settings are live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 12 | Register write data |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Stage can take an input pixel |
| inC0 | input | 8 | Input component 0 |
| inC1 | input | 8 | Input component 1 |
| inC2 | input | 8 | Input component 2 |
| inAlpha | input | 8 | Input alpha |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Consumer can take the output pixel |
| outC0 | output | 8 | Output component 0 |
| outC1 | output | 8 | Output component 1 |
| outC2 | output | 8 | Output component 2 |
| outAlpha | output | 8 | Output alpha |

## Verification
A transformed pixel is due three cycles after the cycle in which it was accepted. The bench samples every handshake on the falling edge, records the accepting cycle next to the expected pixel, and checks that gap whenever the consumer is always ready. After a register write, the bench expects inReady to be low in the very next cycle. After a refused output, it expects the same pixel to be held in the following cycle. A reference model of the registers is updated only after the acceptance check of the write's own cycle, so each pixel is compared against the settings that were live when it entered.

// File: rtl/color_xform_pkg.sv
package color_xform_pkg;

  parameter int COMP_W = 8;
  parameter int COEF_W = 12;
  parameter int FRAC_W = 10;
  parameter int OFS_W  = 10;
  parameter int NCOMP  = 3;
  parameter int REG_AW = 4;

  localparam int REG_DW    = COEF_W;
  localparam int NCOEF     = NCOMP * NCOMP;
  localparam int ACC_W     = COMP_W + COEF_W + 4;
  localparam int PM_W      = 2 * COMP_W;
  localparam int OFS_BASE  = NCOEF;
  localparam int MODE_ADDR = NCOEF + NCOMP;
  localparam int STAGES    = 3;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_MATRIX = 2'd1,
    MODE_PREMUL = 2'd2,
    MODE_ALT    = 2'd3
  } mode_e;

  typedef struct packed {
    logic [NCOEF-1:0][COEF_W-1:0] coef;
    logic [NCOMP-1:0][OFS_W-1:0]  ofs;
    mode_e                        mode;
  } cfg_t;

  typedef struct packed {
    logic advance;
    logic accept;
    logic load;
  } strobe_t;

  function automatic cfg_t resetCfg();
    cfg_t c;
    c = '0;
    for (int r = 0; r < NCOMP; r++) begin
      c.coef[r*NCOMP + r] = COEF_W'(1 << FRAC_W);
    end
    c.mode = MODE_PASS;
    return c;
  endfunction

endpackage

// File: rtl/color_xform_ctrl.sv
module color_xform_ctrl
  import color_xform_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              inValid,
  input  logic              outReady,
  input  logic [STAGES-1:0] pipeOcc,
  output logic              inReady,
  output strobe_t           strobe,
  output cfg_t              activeCfg
);

  cfg_t shadowCfg;
  logic pending;
  logic pipeEmpty;

  always_comb begin
    pipeEmpty      = ~|pipeOcc;
    strobe.advance = !pipeOcc[STAGES-1] || outReady;
    inReady        = strobe.advance && !pending;
    strobe.accept  = inValid && inReady;
    strobe.load    = pending && pipeEmpty;
  end

  // Staging copy: every write lands here first.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= resetCfg();
    end else if (regWrEn) begin
      for (int i = 0; i < NCOEF; i++) begin
        if (regAddr == REG_AW'(i)) shadowCfg.coef[i] <= regWrData[COEF_W-1:0];
      end
      for (int i = 0; i < NCOMP; i++) begin
        if (regAddr == REG_AW'(OFS_BASE + i)) shadowCfg.ofs[i] <= regWrData[OFS_W-1:0];
      end
      if (regAddr == REG_AW'(MODE_ADDR)) shadowCfg.mode <= mode_e'(regWrData[1:0]);
    end
  end

  // Live copy: refreshed only once the pipeline holds no pixel.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      activeCfg <= resetCfg();
    end else begin
      pending <= regWrEn || (pending && !strobe.load);
      if (strobe.load) activeCfg <= shadowCfg;
    end
  end

  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pipeEmpty) |-> $stable(activeCfg));

  // R10
  ready_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !inReady);

endmodule

// File: rtl/color_xform_dp.sv
module color_xform_dp
  import color_xform_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  input  cfg_t                         cfg,
  input  logic [NCOMP-1:0][COMP_W-1:0] inC,
  input  logic [COMP_W-1:0]            inAlpha,
  output logic [STAGES-1:0]            pipeOcc,
  output logic [NCOMP-1:0][COMP_W-1:0] outC,
  output logic [COMP_W-1:0]            outAlpha
);

  localparam logic signed [ACC_W-1:0] RND     = ACC_W'(1 << (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] CMAX    = ACC_W'((1 << COMP_W) - 1);
  localparam logic        [PM_W:0]    PM_HALF = (PM_W+1)'(1 << (COMP_W - 1));

  logic v1, v2, v3;
  logic [COMP_W-1:0] a1, a2, a3;
  logic [NCOMP-1:0][COMP_W-1:0] c1;

  logic signed [ACC_W-1:0] prodNext [NCOEF];
  logic signed [ACC_W-1:0] prod1    [NCOEF];
  logic        [PM_W-1:0]  pmNext   [NCOMP];
  logic        [PM_W-1:0]  pm1      [NCOMP];

  // Stage 1 operands: every matrix product and every alpha product.
  for (genvar gr = 0; gr < NCOMP; gr++) begin : g_prod_row
    for (genvar gc = 0; gc < NCOMP; gc++) begin : g_prod_col
      assign prodNext[gr*NCOMP + gc] =
        $signed({{(ACC_W-COMP_W){1'b0}}, inC[gc]}) *
        $signed({{(ACC_W-COEF_W){cfg.coef[gr*NCOMP + gc][COEF_W-1]}}, cfg.coef[gr*NCOMP + gc]});
    end
    assign pmNext[gr] = {{COMP_W{1'b0}}, inC[gr]} * {{COMP_W{1'b0}}, inAlpha};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (strobe.advance) begin
      v1 <= strobe.accept;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.advance) begin
      for (int i = 0; i < NCOEF; i++) prod1[i] <= prodNext[i];
      for (int i = 0; i < NCOMP; i++) pm1[i] <= pmNext[i];
      c1 <= inC;
      a1 <= inAlpha;
      a2 <= a1;
      a3 <= a2;
    end
  end

  // Stages 2 and 3, one copy per output component.
  for (genvar gr = 0; gr < NCOMP; gr++) begin : g_row
    logic signed [ACC_W-1:0] ofsWide;
    logic signed [ACC_W-1:0] dot;
    logic        [PM_W:0]    pmRnd;
    logic        [COMP_W-1:0] pmQ;
    logic signed [ACC_W-1:0] res2Next;
    logic signed [ACC_W-1:0] res2;
    logic        [COMP_W-1:0] clampNext;
    logic        [COMP_W-1:0] out3;

    always_comb begin
      ofsWide = {{(ACC_W-OFS_W){cfg.ofs[gr][OFS_W-1]}}, cfg.ofs[gr]};
      dot = (ofsWide <<< FRAC_W) + RND;
      for (int k = 0; k < NCOMP; k++) dot = dot + prod1[gr*NCOMP + k];
      pmRnd = {1'b0, pm1[gr]} + PM_HALF;
      pmQ   = COMP_W'((pmRnd + (pmRnd >> COMP_W)) >> COMP_W);
      unique case (cfg.mode)
        MODE_MATRIX: res2Next = dot >>> FRAC_W;
        MODE_PREMUL: res2Next = {{(ACC_W-COMP_W){1'b0}}, pmQ};
        default:     res2Next = {{(ACC_W-COMP_W){1'b0}}, c1[gr]};
      endcase
    end

    always_ff @(posedge clk) begin
      if (strobe.advance) res2 <= res2Next;
    end

    always_comb begin
      if (res2[ACC_W-1])    clampNext = '0;
      else if (res2 > CMAX) clampNext = '1;
      else                  clampNext = res2[COMP_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (strobe.advance) out3 <= clampNext;
    end

    assign outC[gr] = out3;

    // R5
    premul_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      (v3 && cfg.mode == MODE_PREMUL) |-> (out3 <= a3));
  end

  assign pipeOcc  = {v3, v2, v1};
  assign outAlpha = a3;

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (v3 && !strobe.advance) |=> (v3 && $stable(outC) && $stable(outAlpha)));

endmodule

// File: rtl/color_xform.sv
module color_xform
  import color_xform_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [COMP_W-1:0] inC0,
  input  logic [COMP_W-1:0] inC1,
  input  logic [COMP_W-1:0] inC2,
  input  logic [COMP_W-1:0] inAlpha,
  output logic              outValid,
  input  logic              outReady,
  output logic [COMP_W-1:0] outC0,
  output logic [COMP_W-1:0] outC1,
  output logic [COMP_W-1:0] outC2,
  output logic [COMP_W-1:0] outAlpha
);

  strobe_t                      strobe;
  cfg_t                         activeCfg;
  logic [STAGES-1:0]            pipeOcc;
  logic [NCOMP-1:0][COMP_W-1:0] outC;

  color_xform_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .inValid   (inValid),
    .outReady  (outReady),
    .pipeOcc   (pipeOcc),
    .inReady   (inReady),
    .strobe    (strobe),
    .activeCfg (activeCfg)
  );

  color_xform_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfg      (activeCfg),
    .inC      ({inC2, inC1, inC0}),
    .inAlpha  (inAlpha),
    .pipeOcc  (pipeOcc),
    .outC     (outC),
    .outAlpha (outAlpha)
  );

  assign outValid = pipeOcc[STAGES-1];
  assign outC0    = outC[0];
  assign outC1    = outC[1];
  assign outC2    = outC[2];

endmodule

// File: tb/color_xform_tb_top.sv
module color_xform_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [11:0] regWrData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inC0 = '0, inC1 = '0, inC2 = '0, inAlpha = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [7:0] outC0, outC1, outC2, outAlpha;

  always #(CLK_PERIOD/2) clk = ~clk;

  color_xform dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .inValid(inValid), .inReady(inReady), .inC0(inC0), .inC1(inC1), .inC2(inC2),
    .inAlpha(inAlpha), .outValid(outValid), .outReady(outReady),
    .outC0(outC0), .outC1(outC1), .outC2(outC2), .outAlpha(outAlpha)
  );

  int chkCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  bit done = 0;
  bit latChk = 1;
  bit stallStop = 0;

  // Reference register model
  int mCoef [9];
  int mOfs [3];
  int mMode = 0;
  bit writesSeen = 0;

  logic [23:0] eQ [$];
  logic [7:0]  aQ [$];
  string       tQ [$];
  int          cQ [$];

  bit stallPrev = 0;
  bit wrPrev = 0;
  logic [31:0] prevOut = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    chkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  endtask

  function automatic int clampV(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  task automatic pushExpected();
    int c [3];
    int e [3];
    int s, p, v;
    string tag;
    c[0] = inC0; c[1] = inC1; c[2] = inC2;
    tag = "R2";
    if (mMode == 1) begin
      tag = "R3";
      for (int r = 0; r < 3; r++) begin
        s = mOfs[r] * 1024 + 512;
        for (int k = 0; k < 3; k++) s += mCoef[r*3 + k] * c[k];
        v = s >>> 10;
        if (v < 0 || v > 255) tag = "R4";
        e[r] = clampV(v);
      end
    end else if (mMode == 2) begin
      tag = "R5";
      for (int r = 0; r < 3; r++) begin
        p = c[r] * int'(inAlpha) + 128;
        e[r] = (p + (p >> 8)) >> 8;
      end
    end else begin
      for (int r = 0; r < 3; r++) e[r] = c[r];
      if (!writesSeen) tag = "R1";
      else if (mMode == 3) tag = "R9";
    end
    eQ.push_back({8'(e[2]), 8'(e[1]), 8'(e[0])});
    aQ.push_back(inAlpha);
    tQ.push_back(tag);
    cQ.push_back(cyc);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_LIMIT);
      finishRun();
    end
    if (rstN) begin
      if (stallPrev)
        chk(outValid && ({outAlpha, outC2, outC1, outC0} == prevOut), "R8", "held pixel",
            {outAlpha, outC2, outC1, outC0}, prevOut);
      if (wrPrev) chk(!inReady, "R10", "inReady after write", inReady, 0);
      if (outValid && !outReady) chk(!inReady, "R8", "inReady in stall", inReady, 0);
      if (inValid && inReady) pushExpected();
      if (outValid && outReady) begin
        if (eQ.size() == 0) begin
          chk(0, "R7", "unexpected output", 1, 0);
        end else begin
          logic [23:0] e;
          logic [7:0] a;
          string t;
          int ac;
          e = eQ.pop_front(); a = aQ.pop_front(); t = tQ.pop_front(); ac = cQ.pop_front();
          chk({outC2, outC1, outC0} == e, t, "color", {outC2, outC1, outC0}, e);
          chk(outAlpha == a, "R6", "alpha", outAlpha, a);
          if (latChk) chk(cyc - ac == 3, "R7", "latency", cyc - ac, 3);
        end
      end
      stallPrev = outValid && !outReady;
      prevOut = {outAlpha, outC2, outC1, outC0};
      if (regWrEn) begin
        writesSeen = 1;
        if (regAddr < 9) mCoef[regAddr] = int'($signed(regWrData));
        else if (regAddr < 12) mOfs[regAddr - 9] = int'($signed(regWrData[9:0]));
        else if (regAddr == 12) mMode = int'(regWrData[1:0]);
      end
      wrPrev = regWrEn;
    end
  end

  task automatic sendPixel(int c0, int c1, int c2, int a);
    bit ok;
    inValid = 1; inC0 = 8'(c0); inC1 = 8'(c1); inC2 = 8'(c2); inAlpha = 8'(a);
    do begin
      @(negedge clk);
      ok = inReady;
      @(posedge clk); #1;
    end while (!ok);
    inValid = 0;
  endtask

  task automatic regWrite(int addr, int data);
    @(posedge clk); #1;
    regWrEn = 1; regAddr = 4'(addr); regWrData = 12'(data);
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic drain();
    do @(negedge clk); while (eQ.size() != 0);
    @(posedge clk); #1;
  endtask

  task automatic loadCfg(int k [9], int o [3], int mode);
    for (int i = 0; i < 9; i++) regWrite(i, k[i]);
    for (int i = 0; i < 3; i++) regWrite(9 + i, o[i]);
    regWrite(12, mode);
  endtask

  task automatic gridSweep(int step);
    for (int x = 0; x < 256; x += step)
      for (int y = 0; y < 256; y += step)
        for (int z = 0; z < 256; z += step)
          sendPixel(x, y, z, (x + 3*y + 7*z) & 255);
  endtask

  int kA [9] = '{1024, 0, 1436, 1024, -352, -731, 1024, 1815, 0};
  int oA [3] = '{-179, 135, -227};
  int kB [9] = '{2047, -2048, 1000, -1, 512, 2047, 0, 0, 0};
  int oB [3] = '{511, -512, -3};

  initial begin
    for (int i = 0; i < 9; i++) mCoef[i] = (i % 4 == 0) ? 1024 : 0;
    for (int i = 0; i < 3; i++) mOfs[i] = 0;
    repeat (5) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(!outValid, "R1", "outValid after reset", outValid, 0);
    chk(inReady, "R1", "inReady after reset", inReady, 1);
    @(posedge clk); #1;

    // R1: default settings pass pixels unchanged
    sendPixel(10, 200, 77, 33);
    sendPixel(255, 0, 128, 255);
    drain();

    // R2, R6, R7: neutral mode sweep
    regWrite(12, 0);
    for (int i = 0; i < 256; i++) sendPixel(i, 255 - i, (i * 37) & 255, (i * 91) & 255);
    drain();

    // R3, R4: matrix sweeps with two coefficient sets
    loadCfg(kA, oA, 1);
    gridSweep(17);
    drain();
    loadCfg(kB, oB, 1);
    gridSweep(17);
    drain();

    // R5: pre-multiply sweep
    regWrite(12, 2);
    for (int c = 0; c < 256; c++)
      for (int a = 0; a < 256; a += 17) sendPixel(c, 255 - c, c ^ a, a);
    sendPixel(255, 255, 255, 255);
    sendPixel(0, 1, 255, 0);
    drain();

    // R9: mode code 3 acts as neutral; addresses 13..15 are ignored
    regWrite(12, 3);
    for (int i = 0; i < 20; i++) sendPixel(i * 13, i * 7, 255 - i, i);
    drain();
    loadCfg(kA, oA, 1);
    regWrite(13, 12'hABC);
    regWrite(14, 12'h801);
    regWrite(15, 12'h002);
    gridSweep(51);
    drain();

    // R8: random back-pressure
    latChk = 0;
    stallStop = 0;
    fork
      begin
        for (int i = 0; i < 300; i++) sendPixel(i & 255, (i * 5) & 255, (i * 11) & 255, (i * 3) & 255);
        stallStop = 1;
      end
      begin
        while (!stallStop) begin
          @(posedge clk); #1;
          outReady = ($urandom % 3) != 0;
        end
        outReady = 1;
      end
    join
    drain();
    latChk = 1;

    // R10: writes while pixels stream in
    fork
      begin
        for (int i = 0; i < 60; i++) sendPixel((i * 29) & 255, (i * 17) & 255, (i * 43) & 255, (i * 61) & 255);
      end
      begin
        repeat (8) @(posedge clk);
        regWrite(12, 2);
        repeat (5) @(posedge clk);
        regWrite(9, 100);
        regWrite(12, 1);
        regWrite(0, -500);
      end
    join
    drain();

    finishRun();
  end

endmodule